// File: doc/BRIEF.md
# Bit-Serial Modular Squarer with Segmented Carries

The block computes the square of an operand modulo a fixed odd modulus: result = x·x mod n, with n a design parameter. This is the encryption step of a factoring-based public-key scheme when the additive key term is zero. The operand arrives in parallel on a start pulse and is latched. The unit then works as a bit-serial modular multiplier. Both multiplicand and multiplier are the latched operand, and the multiplier bits are consumed one per step, most significant bit first.

Each step follows a fixed order. The running sum is shifted left by one bit. The operand is added if the current multiplier bit is one. Then the two's complement of n is added repeatedly for as long as the sum stays at or above n. A subtraction that borrows is undone by adding n back. One adder does all of this work. It ripples within fixed-width segments, and the carry out of each segment is saved in a flip-flop instead of being passed on. Before any shift, and before any subtraction is judged, extra adder passes with a zero operand fold the saved carries back into the sum until none remain.

A main state machine handles the start/busy/done handshake. A second state machine sequences the arithmetic. Two enable-gated LFSR counters bound the number of multiplication steps and the number of realignment passes.

Top module: `sq_modsq`

## Requirements
- R1: For every operand x < n, the block reports result_o = (x·x) mod n in the cycle where done_o is high.
- R2: A start_i sampled high while idle raises busy_o from the next cycle. done_o is high for exactly one cycle, and busy_o is low in that cycle.
- R3: A start_i pulse while busy_o is high has no effect. The running operation completes with the result of the original operand.
- R4: The operand is captured when start_i is accepted. Later changes of x_i during the run do not alter the result.
- R5: After done_o, result_o holds its value until the next accepted start, whatever x_i does.
- R6: Saved carries are cleared by realignment passes, and at most NSEG−1 passes are needed, where NSEG is the number of SEG-bit segments in the sum register.
- R7: Every shift happens only on a fully realigned sum below n. The result reported with done_o is non-redundant and below n.
- R8: After reset, busy_o and done_o are low and result_o is zero.
- R9: The boundary operands 0, 1, 2, n−2 and n−1 give 0, 1, 4, 4 and 1.
- R10: With the default 64-bit width and segment size 8, the block produces correct residues for full-width operands.
- R11: The multiplication step counter advances exactly W times per operation and is never advanced past its terminal state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts an operation when the block is idle |
| x_i | input | W | Operand, must be below the modulus |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when result_o is valid |
| result_o | output | W | Residue x·x mod n |

## Verification
The hardest behaviour to provoke is a long carry chain that needs every realignment pass. This happens when a segment fills with ones just as a carry arrives from below. It also happens when a subtraction of n sits right at the borrow boundary, so that it must be accepted once and then rejected. The operands n−1 and n−2, together with a dense sweep of operands on a small 12-bit configuration with 4-bit segments, drive sums through every segment boundary and through double subtractions. The realignment bound and the no-shift-while-redundant rule are watched during every one of those runs. A full-width instance at the default parameters repeats the boundary operands and adds mixed-pattern operands.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;

  typedef enum logic [1:0] {OP_ZERO, OP_X, OP_NEGN, OP_N} op_sel_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_ADDX, S_SUB, S_CHECK, S_RESTORE, S_ALIGN, S_FIN
  } seq_e;

  typedef enum logic [1:0] {M_IDLE, M_BUSY, M_DONE} main_e;

  // smallest register width whose LFSR period exceeds the limit
  function automatic int lfsr_width(input int limit);
    for (int w = 3; w <= 16; w++) begin
      if (((1 << w) - 1) > limit) return w;
    end
    return 16;
  endfunction

  // primitive feedback masks, bit t-1 set for tap t
  function automatic logic [15:0] lfsr_taps(input int w);
    case (w)
      3:       return 16'h0006;
      4:       return 16'h000C;
      5:       return 16'h0014;
      6:       return 16'h0030;
      7:       return 16'h0060;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0829;
      13:      return 16'h100D;
      14:      return 16'h2015;
      15:      return 16'h6000;
      default: return 16'hD008;
    endcase
  endfunction

endpackage

// File: rtl/sq_lfsr_cnt.sv
`timescale 1ns/1ps
module sq_lfsr_cnt #(
  parameter int LIMIT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic done_o
);
  localparam int LW = sq_pkg::lfsr_width(LIMIT);
  localparam logic [15:0] TAPS = sq_pkg::lfsr_taps(LW);

  function automatic logic [LW-1:0] lfsr_next(input logic [LW-1:0] v);
    return {v[LW-2:0], ^(v & TAPS[LW-1:0])};
  endfunction

  function automatic logic [LW-1:0] term_state();
    logic [LW-1:0] v;
    v = '1;
    for (int i = 0; i < LIMIT; i++) v = lfsr_next(v);
    return v;
  endfunction

  localparam logic [LW-1:0] SEED = '1;
  localparam logic [LW-1:0] TERM = term_state();

  logic [LW-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (clr_i)  q <= SEED;
    else if (inc_i)  q <= lfsr_next(q);
  end

  assign done_o = (q == TERM);

  a_r11_lfsr_alive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);

endmodule

// File: rtl/sq_seg_adder.sv
`timescale 1ns/1ps
module sq_seg_adder #(
  parameter int SEG  = 8,
  parameter int NSEG = 9
) (
  input  logic [SEG*NSEG-1:0] a_i,
  input  logic [SEG*NSEG-1:0] b_i,
  input  logic [NSEG-1:0]     cin_i,
  output logic [SEG*NSEG-1:0] sum_o,
  output logic [NSEG-1:0]     cout_o
);
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    logic [SEG:0] seg_sum;
    assign seg_sum = {1'b0, a_i[g*SEG +: SEG]} + {1'b0, b_i[g*SEG +: SEG]}
                   + {{SEG{1'b0}}, cin_i[g]};
    assign sum_o[g*SEG +: SEG] = seg_sum[SEG-1:0];
    assign cout_o[g]           = seg_sum[SEG];
  end
endmodule

// File: rtl/sq_ctrl.sv
`timescale 1ns/1ps
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int W    = 64,
  parameter int NSEG = 9
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      mul_bit_i,
  input  logic      carry_zero_i,
  input  logic      top_flag_i,
  output logic      busy_o,
  output logic      done_o,
  output logic      load_o,
  output logic      shift_o,
  output logic      pass_o,
  output logic      sub_o,
  output op_sel_e   op_o
);
  main_e main_q, main_d;
  seq_e  seq_q, seq_d, ret_q, ret_d;
  logic  step_inc, step_done, align_clr, align_inc, align_done, finish;

  sq_lfsr_cnt #(.LIMIT(W)) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(load_o), .inc_i(step_inc), .done_o(step_done)
  );

  sq_lfsr_cnt #(.LIMIT(NSEG-1)) u_align (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(align_clr), .inc_i(align_inc), .done_o(align_done)
  );

  assign load_o = (main_q == M_IDLE) && start_i;
  assign busy_o = (main_q == M_BUSY);
  assign done_o = (main_q == M_DONE);

  always_comb begin
    main_d = main_q;
    unique case (main_q)
      M_IDLE:  if (start_i) main_d = M_BUSY;
      M_BUSY:  if (finish)  main_d = M_DONE;
      M_DONE:  main_d = M_IDLE;
      default: main_d = M_IDLE;
    endcase
  end

  always_comb begin
    seq_d     = seq_q;
    ret_d     = ret_q;
    shift_o   = 1'b0;
    pass_o    = 1'b0;
    sub_o     = 1'b0;
    op_o      = OP_ZERO;
    step_inc  = 1'b0;
    align_clr = 1'b0;
    align_inc = 1'b0;
    finish    = 1'b0;
    unique case (seq_q)
      S_IDLE: if (load_o) seq_d = S_SHIFT;
      S_SHIFT: begin
        if (step_done) seq_d = S_FIN;
        else begin
          shift_o  = 1'b1;
          step_inc = 1'b1;
          seq_d    = mul_bit_i ? S_ADDX : S_SUB;
        end
      end
      S_ADDX: begin
        pass_o = 1'b1; op_o = OP_X;
        seq_d = S_ALIGN; ret_d = S_SUB; align_clr = 1'b1;
      end
      S_SUB: begin
        pass_o = 1'b1; op_o = OP_NEGN; sub_o = 1'b1;
        seq_d = S_ALIGN; ret_d = S_CHECK; align_clr = 1'b1;
      end
      // top carry set means no borrow: keep result and try again
      S_CHECK: seq_d = top_flag_i ? S_SUB : S_RESTORE;
      S_RESTORE: begin
        pass_o = 1'b1; op_o = OP_N;
        seq_d = S_ALIGN; ret_d = S_SHIFT; align_clr = 1'b1;
      end
      S_ALIGN: begin
        if (carry_zero_i) seq_d = ret_q;
        else begin
          pass_o    = 1'b1;
          align_inc = 1'b1;
        end
      end
      S_FIN: begin
        finish = 1'b1;
        seq_d  = S_IDLE;
      end
      default: seq_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= M_IDLE;
      seq_q  <= S_IDLE;
      ret_q  <= S_IDLE;
    end else begin
      main_q <= main_d;
      seq_q  <= seq_d;
      ret_q  <= ret_d;
    end
  end

  a_r2_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> busy_o);
  a_r2_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_no_restart_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (busy_o || done_o));
  a_r6_align_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_q == S_ALIGN && align_done) |-> carry_zero_i);
  a_r11_step_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_inc |-> !step_done);

endmodule

// File: rtl/sq_modsq.sv
`timescale 1ns/1ps
module sq_modsq
  import sq_pkg::*;
#(
  parameter int           W     = 64,
  parameter int           SEG   = 8,
  parameter logic [W-1:0] N_MOD = 64'hF1E2_D3C4_B5A6_9787
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] x_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  // sum must hold 2n + x < 3n, hence two spare bits
  localparam int NSEG_RAW = (W + 2 + SEG - 1) / SEG;
  localparam int NSEG     = (NSEG_RAW < 2) ? 2 : NSEG_RAW;
  localparam int SW       = NSEG * SEG;
  localparam int CW       = NSEG - 1;
  localparam logic [SW-1:0] N_EXT = {{(SW-W){1'b0}}, N_MOD};
  localparam logic [SW-1:0] NEG_N = ~N_EXT + {{(SW-1){1'b0}}, 1'b1};

  logic [W-1:0]  x_q, mul_q;
  logic [SW-1:0] s_q, operand, sum;
  logic [CW-1:0] c_q;
  logic [NSEG-1:0] cout;
  logic          top_q;
  logic          load, shift, pass, sub;
  op_sel_e       op_sel;

  sq_ctrl #(.W(W), .NSEG(NSEG)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mul_bit_i(mul_q[W-1]), .carry_zero_i(c_q == '0), .top_flag_i(top_q),
    .busy_o(busy_o), .done_o(done_o), .load_o(load), .shift_o(shift),
    .pass_o(pass), .sub_o(sub), .op_o(op_sel)
  );

  always_comb begin
    unique case (op_sel)
      OP_X:    operand = {{(SW-W){1'b0}}, x_q};
      OP_NEGN: operand = NEG_N;
      OP_N:    operand = N_EXT;
      default: operand = '0;
    endcase
  end

  sq_seg_adder #(.SEG(SEG), .NSEG(NSEG)) u_add (
    .a_i(s_q), .b_i(operand), .cin_i({c_q, 1'b0}), .sum_o(sum), .cout_o(cout)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; mul_q <= '0; s_q <= '0; c_q <= '0; top_q <= 1'b0;
    end else if (load) begin
      x_q <= x_i; mul_q <= x_i; s_q <= '0; c_q <= '0; top_q <= 1'b0;
    end else if (shift) begin
      s_q   <= {s_q[SW-2:0], 1'b0};
      mul_q <= {mul_q[W-2:0], 1'b0};
    end else if (pass) begin
      s_q   <= sum;
      c_q   <= cout[CW-1:0];
      top_q <= sub ? cout[NSEG-1] : (top_q | cout[NSEG-1]);
    end
  end

  assign result_o = s_q[W-1:0];

  a_r7_shift_realigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift |-> (c_q == '0 && s_q < N_EXT));
  a_r7_done_reduced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (c_q == '0 && s_q < N_EXT));
  a_r4_operand_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(x_q));
  a_r5_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load) |=> $stable(result_o));

endmodule

// File: tb/sq_modsq_tb.sv
`timescale 1ns/1ps
module sq_modsq_tb;
  localparam int          WS = 12;
  localparam logic [11:0] NS = 12'd3001;
  localparam logic [63:0] NW = 64'hF1E2_D3C4_B5A6_9787;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        start_s = 1'b0, start_w = 1'b0;
  logic [11:0] x_s = '0, res_s;
  logic [63:0] x_w = '0, res_w;
  logic        busy_s, done_s, busy_w, done_w;

  int n_chk = 0, n_err = 0;

  sq_modsq #(.W(WS), .SEG(4), .N_MOD(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_s), .x_i(x_s),
    .busy_o(busy_s), .done_o(done_s), .result_o(res_s)
  );

  sq_modsq #(.W(64), .SEG(8), .N_MOD(NW)) u_wide (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_w), .x_i(x_w),
    .busy_o(busy_w), .done_o(done_w), .result_o(res_w)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_small(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done_s) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_small(input logic [11:0] x, input string req);
    bit seen;
    logic [31:0] e;
    e = (32'(x) * 32'(x)) % 32'(NS);
    x_s = x; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    wait_small(seen);
    check(seen && res_s == e[11:0] && res_s < NS, req, 128'(res_s), 128'(e));
    @(negedge clk);
  endtask

  task automatic run_wide(input logic [63:0] x);
    bit seen;
    logic [127:0] e;
    e = ({64'd0, x} * {64'd0, x}) % {64'd0, NW};
    x_w = x; start_w = 1'b1;
    @(negedge clk); start_w = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (done_w) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check(seen && {64'd0, res_w} == e, "R10", 128'(res_w), e);
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit seen;
    logic [11:0] held;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(!busy_s && !done_s && res_s == 0, "R8", {busy_s, done_s, res_s}, 0);
    check(!busy_w && !done_w && res_w == 0, "R8", {busy_w, done_w, res_w}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 handshake timing
    x_s = 12'd1234; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    check(busy_s && !done_s, "R2", {busy_s, done_s}, 2'b10);
    wait_small(seen);
    check(seen && !busy_s, "R2", {seen, busy_s}, 2'b10);
    check(res_s == 12'((1234 * 1234) % 3001), "R1", res_s, (1234 * 1234) % 3001);
    @(negedge clk);
    check(!done_s && !busy_s, "R2", {done_s, busy_s}, 0);

    // R5 result held after done while x_i moves
    held = res_s;
    for (int i = 0; i < 10; i++) begin x_s = 12'(i * 397); @(negedge clk); end
    check(res_s == held && !busy_s, "R5", res_s, held);

    // R9 boundary operands
    run_small(12'd0, "R9");
    run_small(12'd1, "R9");
    run_small(12'd2, "R9");
    run_small(NS - 12'd2, "R9");
    run_small(NS - 12'd1, "R9");

    // R3/R4 start pulse and operand change while busy
    x_s = 12'd2999; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    repeat (5) @(negedge clk);
    x_s = 12'd17; start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    x_s = 12'd555;
    repeat (30) @(negedge clk);
    check(busy_s, "R3", busy_s, 1);
    wait_small(seen);
    check(seen && res_s == 12'((2999 * 2999) % 3001), "R3", res_s, (2999 * 2999) % 3001);
    check(res_s != 12'((17 * 17) % 3001), "R4", res_s, (2999 * 2999) % 3001);
    @(negedge clk);

    // R1/R7 sweep over the small configuration
    for (int x = 3; x < 3001; x += 11) run_small(12'(x), "R1");

    // R10 full-width configuration
    run_wide(64'd0);
    run_wide(64'd1);
    run_wide(NW - 64'd1);
    run_wide(64'h0123_4567_89AB_CDEF);
    run_wide(64'hDEAD_BEEF_1234_5678);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule